// File: doc/BRIEF.md
# In-System Programming Stage Sequencer

This block drives a target's nonvolatile configuration memory through a full programming session over a serial shift path. A session is started from the control pins. It walks through a timed series of stages. Instructions, addresses and data go out on `tdi`, one bit for each cycle that `tck_en` is high. Read-back and identity data come back on `tdo`. Timed pulses are reported on `pulse` and `pulse_kind`. All durations are counted in clock cycles, derived from the `CLK_HZ` parameter.

Two session modes exist:
- **Full mode** (`verify_only` = 0): enter, identity check, bulk erase, program all addresses, verify all addresses, exit.
- **Verify-only mode** (`verify_only` = 1): enter, identity check, verify all addresses, exit.

A pattern source supplies the expected word for each address as a valid/ready stream:
- The block raises `pat_ready` only while it waits for a word, and it holds `pat_addr` steady during that wait.
- A word is taken on a cycle where `pat_valid` and `pat_ready` are both high.
- The source may hold `pat_valid` low for any number of cycles. The sequencer then stalls in place, with no shifting and no pulse.
- Words are requested in ascending address order, once per program pass and once per verify pass.

Top module: `isp_sequencer`

## Requirements
- R1: In full mode, `stage` takes the nonzero values 1 (enter), 2 (identity), 3 (erase), 4 (program), 5 (verify), 6 (exit) in exactly that order. Stage 0 means idle or finished.
- R2: In verify-only mode, `stage` takes only the values 1, 2, 5, 6 in that order, and no erase pulse and no program pulse is issued.
- R3: The enter stage lasts exactly CLK_HZ/1000 cycles. The exit stage lasts exactly CLK_HZ/1000 cycles, and `done` rises on the cycle right after it.
- R4: Bulk erase shifts the erase opcode, then issues exactly one pulse with `pulse_kind` = 1 that lasts CLK_HZ/10 cycles.
- R5: For every address from 0 to NUM_ADDR-1, the program stage shifts the following and then issues a PROG_CYC-cycle pulse with `pulse_kind` = 2:
  - the program opcode;
  - the address (ADDR_W bits);
  - the pattern word (DATA_W bits).
- R6: For every address, the verify stage does the following, then compares the captured word with the pattern word:
  - shifts the verify opcode and the address;
  - issues a READ_CYC-cycle pulse with `pulse_kind` = 3;
  - captures DATA_W bits from `tdo`.
- R7: The identity stage shifts the identity opcode and captures ID_W bits. If they differ from ID_VALUE:
  - `id_fail` is set;
  - the run goes straight to exit;
  - no pulse of any kind follows.
- R8: A verify mismatch sets a sticky `vfy_fail`, and `fail_addr` keeps the first failing address. Verification still covers every address.
- R9: Every serial word is sent least-significant bit first, one bit for each cycle that `tck_en` is high. `tdo` is sampled in that same cycle. The opcodes are OP_ID, OP_ERASE, OP_PROG and OP_VERIFY, each INSTR_W bits wide.
- R10: Pattern words are accepted only when `pat_valid` and `pat_ready` are both high, with `pat_addr` counting from 0 up. While `pat_valid` is low, `pat_ready` and `pat_addr` hold.
- R11: `start` is honoured only when `busy` is low. Starting a run clears `done`, `id_fail`, `vfy_fail` and `fail_addr`. `done` stays high until the next start.
- R12: After reset, `busy`, `done`, `tck_en`, `pulse`, `pat_ready`, `id_fail` and `vfy_fail` are 0, and `stage` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session (ignored while busy) |
| verify_only | input | 1 | Mode sampled at start: 1 skips erase and program |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished; held until next start |
| stage | output | 3 | Current stage code (see R1) |
| id_fail | output | 1 | Sticky identity mismatch |
| vfy_fail | output | 1 | Sticky verify mismatch |
| fail_addr | output | ADDR_W | First address that failed verify |
| pat_addr | output | ADDR_W | Address whose expected word is wanted |
| pat_data | input | DATA_W | Expected word from the pattern source |
| pat_valid | input | 1 | Pattern word present |
| pat_ready | output | 1 | Sequencer waiting for a pattern word |
| tck_en | output | 1 | Shift enable, one bit per high cycle |
| tdi | output | 1 | Serial data to target |
| tdo | input | 1 | Serial data from target |
| pulse | output | 1 | Timed erase/program/read pulse active |
| pulse_kind | output | 2 | 0 none, 1 erase, 2 program, 3 read |

## Verification
The control outputs change at different points relative to `start`:
- Because `start` is registered, `stage` reads 1 and `busy` reads 1 from the first cycle after the edge that samples `start`.
- `done` rises one cycle after the last exit-stage cycle.
- The flag outputs change on the edge that leaves a compare step. That compare step comes one cycle after the last captured bit.

The bench drives every input on the falling edge and samples every output on the falling edge. It counts stage and pulse cycles at rising edges, so each duration is exact to the cycle. Serial fields are decoded bit by bit at the rising edge where `tck_en` is high. The pulse effects of a target are applied on the first rising edge where `pulse` is high, which is the same moment the sequencer's timer starts counting.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

  typedef enum logic [2:0] {
    STG_IDLE   = 3'd0,
    STG_ENTER  = 3'd1,
    STG_ID     = 3'd2,
    STG_ERASE  = 3'd3,
    STG_PROG   = 3'd4,
    STG_VERIFY = 3'd5,
    STG_EXIT   = 3'd6
  } stage_e;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_ERASE = 2'd1,
    PK_PROG  = 2'd2,
    PK_READ  = 2'd3
  } pulse_kind_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_ENTER,
    S_ID_INS,
    S_ID_DAT,
    S_ID_CHK,
    S_ER_INS,
    S_ER_PULSE,
    S_PG_FETCH,
    S_PG_INS,
    S_PG_ADR,
    S_PG_DAT,
    S_PG_PULSE,
    S_VF_INS,
    S_VF_ADR,
    S_VF_PULSE,
    S_VF_FETCH,
    S_VF_DAT,
    S_VF_CHK,
    S_EXIT,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/isp_shifter.sv
module isp_shifter #(
  parameter int MAXW = 16,
  parameter int CW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MAXW-1:0] word,
  input  logic [CW-1:0]   nbits,
  input  logic            tdo,
  output logic            tck_en,
  output logic            tdi,
  output logic            last,
  output logic [MAXW-1:0] cap
);

  logic            active;
  logic [MAXW-1:0] sr;
  logic [CW-1:0]   idx;
  logic [CW-1:0]   nb;

  assign tck_en = active;
  assign tdi    = active ? sr[idx] : 1'b0;
  assign last   = active && (idx == nb - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sr     <= '0;
      idx    <= '0;
      nb     <= '0;
      cap    <= '0;
    end else begin
      if (active) begin
        cap[idx] <= tdo;
        idx      <= idx + CW'(1);
        if (last) active <= 1'b0;
      end
      if (start) begin
        active <= 1'b1;
        sr     <= word;
        idx    <= '0;
        nb     <= nbits;
      end
    end
  end

  // A new word may only begin once the previous word is on its final bit.
  assert_no_start_midword_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active || last));

endmodule

// File: rtl/isp_timer.sv
module isp_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] load,
  output logic          active,
  output logic          last
);

  logic [TW-1:0] cnt;

  assign last = active && (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= load;
    end else if (active) begin
      cnt <= cnt - TW'(1);
      if (last) active <= 1'b0;
    end
  end

  // Timed intervals never overlap: a new one starts only from idle.
  assert_timer_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/isp_sequencer.sv
module isp_sequencer
  import isp_seq_pkg::*;
#(
  parameter int               CLK_HZ    = 100_000_000,
  parameter int               INSTR_W   = 8,
  parameter int               ADDR_W    = 4,
  parameter int               NUM_ADDR  = 16,
  parameter int               DATA_W    = 16,
  parameter int               ID_W      = 16,
  parameter logic [ID_W-1:0]  ID_VALUE  = 16'hA5C3,
  parameter logic [INSTR_W-1:0] OP_ID     = 8'h59,
  parameter logic [INSTR_W-1:0] OP_ERASE  = 8'h92,
  parameter logic [INSTR_W-1:0] OP_PROG   = 8'h2F,
  parameter logic [INSTR_W-1:0] OP_VERIFY = 8'h05,
  parameter int               PROG_CYC  = 1000,
  parameter int               READ_CYC  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              verify_only,
  output logic              busy,
  output logic              done,
  output logic [2:0]        stage,
  output logic              id_fail,
  output logic              vfy_fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] pat_addr,
  input  logic [DATA_W-1:0] pat_data,
  input  logic              pat_valid,
  output logic              pat_ready,
  output logic              tck_en,
  output logic              tdi,
  input  logic              tdo,
  output logic              pulse,
  output logic [1:0]        pulse_kind
);

  localparam int MODE_CYC  = CLK_HZ / 1000;
  localparam int ERASE_CYC = CLK_HZ / 10;
  localparam int W_AB      = (INSTR_W > ADDR_W) ? INSTR_W : ADDR_W;
  localparam int W_CD      = (DATA_W > ID_W) ? DATA_W : ID_W;
  localparam int MAXW      = (W_AB > W_CD) ? W_AB : W_CD;
  localparam int SCW       = $clog2(MAXW + 1);
  localparam int T_AB      = (MODE_CYC > ERASE_CYC) ? MODE_CYC : ERASE_CYC;
  localparam int T_CD      = (PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC;
  localparam int TMAX      = (T_AB > T_CD) ? T_AB : T_CD;
  localparam int TW        = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_ADDR - 1);

  seq_state_e        st, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_q;
  logic              mode_q;

  logic              sh_start, sh_last;
  logic [MAXW-1:0]   sh_word, sh_cap;
  logic [SCW-1:0]    sh_nb;
  logic              tm_start, tm_last, tm_active;
  logic [TW-1:0]     tm_load;

  logic id_ok, at_last, vf_miss;

  assign id_ok   = (sh_cap[ID_W-1:0] == ID_VALUE);
  assign at_last = (addr_q == LAST_ADDR);
  assign vf_miss = (sh_cap[DATA_W-1:0] != word_q);

  // Next-state selection
  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE, S_DONE: if (start)     nxt = S_ENTER;
      S_ENTER:        if (tm_last)   nxt = S_ID_INS;
      S_ID_INS:       if (sh_last)   nxt = S_ID_DAT;
      S_ID_DAT:       if (sh_last)   nxt = S_ID_CHK;
      S_ID_CHK:       nxt = !id_ok ? S_EXIT : (mode_q ? S_VF_INS : S_ER_INS);
      S_ER_INS:       if (sh_last)   nxt = S_ER_PULSE;
      S_ER_PULSE:     if (tm_last)   nxt = S_PG_FETCH;
      S_PG_FETCH:     if (pat_valid) nxt = S_PG_INS;
      S_PG_INS:       if (sh_last)   nxt = S_PG_ADR;
      S_PG_ADR:       if (sh_last)   nxt = S_PG_DAT;
      S_PG_DAT:       if (sh_last)   nxt = S_PG_PULSE;
      S_PG_PULSE:     if (tm_last)   nxt = at_last ? S_VF_INS : S_PG_FETCH;
      S_VF_INS:       if (sh_last)   nxt = S_VF_ADR;
      S_VF_ADR:       if (sh_last)   nxt = S_VF_PULSE;
      S_VF_PULSE:     if (tm_last)   nxt = S_VF_FETCH;
      S_VF_FETCH:     if (pat_valid) nxt = S_VF_DAT;
      S_VF_DAT:       if (sh_last)   nxt = S_VF_CHK;
      S_VF_CHK:       nxt = at_last ? S_EXIT : S_VF_INS;
      S_EXIT:         if (tm_last)   nxt = S_DONE;
      default:        nxt = S_IDLE;
    endcase
  end

  // Shift launch on entry to a shifting state
  always_comb begin
    sh_word = '0;
    sh_nb   = '0;
    unique case (nxt)
      S_ID_INS: begin sh_word = MAXW'(OP_ID);     sh_nb = SCW'(INSTR_W); end
      S_ID_DAT: begin sh_word = '0;               sh_nb = SCW'(ID_W);    end
      S_ER_INS: begin sh_word = MAXW'(OP_ERASE);  sh_nb = SCW'(INSTR_W); end
      S_PG_INS: begin sh_word = MAXW'(OP_PROG);   sh_nb = SCW'(INSTR_W); end
      S_PG_ADR: begin sh_word = MAXW'(addr_q);    sh_nb = SCW'(ADDR_W);  end
      S_PG_DAT: begin sh_word = MAXW'(word_q);    sh_nb = SCW'(DATA_W);  end
      S_VF_INS: begin sh_word = MAXW'(OP_VERIFY); sh_nb = SCW'(INSTR_W); end
      S_VF_ADR: begin sh_word = MAXW'(addr_q);    sh_nb = SCW'(ADDR_W);  end
      S_VF_DAT: begin sh_word = '0;               sh_nb = SCW'(DATA_W);  end
      default: ;
    endcase
  end
  assign sh_start = (nxt != st) && (sh_nb != '0);

  // Timer launch on entry to a timed state
  always_comb begin
    tm_load = '0;
    unique case (nxt)
      S_ENTER, S_EXIT: tm_load = TW'(MODE_CYC);
      S_ER_PULSE:      tm_load = TW'(ERASE_CYC);
      S_PG_PULSE:      tm_load = TW'(PROG_CYC);
      S_VF_PULSE:      tm_load = TW'(READ_CYC);
      default: ;
    endcase
  end
  assign tm_start = (nxt != st) && (tm_load != '0);

  isp_shifter #(.MAXW(MAXW), .CW(SCW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sh_start),
    .word   (sh_word),
    .nbits  (sh_nb),
    .tdo    (tdo),
    .tck_en (tck_en),
    .tdi    (tdi),
    .last   (sh_last),
    .cap    (sh_cap)
  );

  isp_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tm_start),
    .load   (tm_load),
    .active (tm_active),
    .last   (tm_last)
  );

  // Sequencer state and result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      word_q    <= '0;
      mode_q    <= 1'b0;
      id_fail   <= 1'b0;
      vfy_fail  <= 1'b0;
      fail_addr <= '0;
    end else begin
      st <= nxt;
      unique case (st)
        S_IDLE, S_DONE: if (start) begin
          mode_q    <= verify_only;
          id_fail   <= 1'b0;
          vfy_fail  <= 1'b0;
          fail_addr <= '0;
          addr_q    <= '0;
        end
        S_ID_CHK: begin
          addr_q <= '0;
          if (!id_ok) id_fail <= 1'b1;
        end
        S_PG_FETCH, S_VF_FETCH: if (pat_valid) word_q <= pat_data;
        S_PG_PULSE: if (tm_last) addr_q <= at_last ? '0 : addr_q + ADDR_W'(1);
        S_VF_CHK: begin
          if (vf_miss) begin
            vfy_fail <= 1'b1;
            if (!vfy_fail) fail_addr <= addr_q;
          end
          if (!at_last) addr_q <= addr_q + ADDR_W'(1);
        end
        default: ;
      endcase
    end
  end

  // Output decode
  always_comb begin
    unique case (st)
      S_ENTER:                                     stage = STG_ENTER;
      S_ID_INS, S_ID_DAT, S_ID_CHK:                stage = STG_ID;
      S_ER_INS, S_ER_PULSE:                        stage = STG_ERASE;
      S_PG_FETCH, S_PG_INS, S_PG_ADR, S_PG_DAT,
      S_PG_PULSE:                                  stage = STG_PROG;
      S_VF_INS, S_VF_ADR, S_VF_PULSE, S_VF_FETCH,
      S_VF_DAT, S_VF_CHK:                          stage = STG_VERIFY;
      S_EXIT:                                      stage = STG_EXIT;
      default:                                     stage = STG_IDLE;
    endcase
  end

  always_comb begin
    pulse_kind = PK_NONE;
    if (tm_active) begin
      unique case (st)
        S_ER_PULSE: pulse_kind = PK_ERASE;
        S_PG_PULSE: pulse_kind = PK_PROG;
        S_VF_PULSE: pulse_kind = PK_READ;
        default:    pulse_kind = PK_NONE;
      endcase
    end
  end

  assign pulse     = (pulse_kind != PK_NONE);
  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);
  assign pat_ready = (st == S_PG_FETCH) || (st == S_VF_FETCH);
  assign pat_addr  = addr_q;

  // After an identity mismatch no pulse of any kind may follow.
  assert_no_pulse_after_idfail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_fail |-> !pulse);

  // Erase pulses belong only to full-mode sessions.
  assert_erase_only_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && pulse_kind == PK_ERASE) |-> !mode_q);

  // A stalled pattern request keeps its address and its ready.
  assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_ready && !pat_valid) |=> (pat_ready && $stable(pat_addr)));

  // The first failing address is kept once the sticky flag is up.
  assert_failaddr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_fail && $past(vfy_fail)) |-> $stable(fail_addr));

  // Completion is reported only straight out of the exit stage.
  assert_done_after_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(stage) == STG_EXIT));

endmodule

// File: tb/tb_isp_sequencer.sv
module tb_isp_sequencer;

  localparam int CLK_HZ = 20000;
  localparam int IW = 8, AW = 3, NA = 8, DW = 8, IDW = 8;
  localparam logic [7:0] IDV = 8'hC6;
  localparam logic [7:0] OPI = 8'h59, OPE = 8'h92, OPP = 8'h2F, OPV = 8'h05;
  localparam int PCYC = 5, RCYC = 3;
  localparam int MODE_CYC = CLK_HZ / 1000;
  localparam int ERASE_CYC = CLK_HZ / 10;

  logic clk = 0, rst_n = 0, start = 0, verify_only = 0;
  logic busy, done, id_fail, vfy_fail, pat_ready, tck_en, tdi, tdo, pulse;
  logic [2:0] stage;
  logic [1:0] pulse_kind;
  logic [AW-1:0] fail_addr, pat_addr;
  logic [DW-1:0] pat_data;
  logic pat_valid;

  always #4 clk = ~clk;

  isp_sequencer #(
    .CLK_HZ(CLK_HZ), .INSTR_W(IW), .ADDR_W(AW), .NUM_ADDR(NA), .DATA_W(DW),
    .ID_W(IDW), .ID_VALUE(IDV), .OP_ID(OPI), .OP_ERASE(OPE), .OP_PROG(OPP),
    .OP_VERIFY(OPV), .PROG_CYC(PCYC), .READ_CYC(RCYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .verify_only(verify_only),
    .busy(busy), .done(done), .stage(stage), .id_fail(id_fail),
    .vfy_fail(vfy_fail), .fail_addr(fail_addr), .pat_addr(pat_addr),
    .pat_data(pat_data), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .tck_en(tck_en), .tdi(tdi), .tdo(tdo), .pulse(pulse), .pulse_kind(pulse_kind)
  );

  int checks = 0, errors = 0;
  logic clr = 0;
  logic [7:0] tgt_id = IDV;
  logic [DW-1:0] pat [NA];
  int stall_n = 0;

  // Target model
  int fld, bitn, ta;
  logic [15:0] acc;
  logic [7:0] td, rd;
  logic [7:0] mem [NA];
  logic pulse_d;
  int erase_cnt, prog_cnt, read_cnt, erase_len, prog_len, bad_op;

  function automatic int fw(int f);
    case (f)
      0: return IW;
      1: return IDW;
      2, 4: return AW;
      default: return DW;
    endcase
  endfunction

  assign tdo = (fld == 1) ? tgt_id[bitn] : (fld == 5) ? rd[bitn] : 1'b0;

  always @(posedge clk) begin : model
    logic [15:0] v;
    pulse_d <= pulse;
    if (!rst_n) begin
      fld <= 0; bitn <= 0; acc <= '0; ta <= 0; td <= '0; rd <= '0;
      for (int i = 0; i < NA; i++) mem[i] <= '0;
      erase_cnt <= 0; prog_cnt <= 0; read_cnt <= 0;
      erase_len <= 0; prog_len <= 0; bad_op <= 0;
    end else begin
      if (clr) begin
        erase_cnt <= 0; prog_cnt <= 0; read_cnt <= 0;
        erase_len <= 0; prog_len <= 0; bad_op <= 0;
      end
      if (tck_en) begin
        v = acc;
        v[bitn] = tdi;
        if (bitn == fw(fld) - 1) begin
          bitn <= 0;
          acc <= '0;
          case (fld)
            0: begin
              if (v[7:0] == OPI) fld <= 1;
              else if (v[7:0] == OPP) fld <= 2;
              else if (v[7:0] == OPV) fld <= 4;
              else begin
                fld <= 0;
                if (v[7:0] != OPE) bad_op <= bad_op + 1;
              end
            end
            2: begin ta <= int'(v[AW-1:0]); fld <= 3; end
            3: begin td <= v[7:0]; fld <= 0; end
            4: begin ta <= int'(v[AW-1:0]); fld <= 0; end
            default: fld <= 0;
          endcase
        end else begin
          acc <= v;
          bitn <= bitn + 1;
        end
      end
      if (pulse && !pulse_d) begin
        case (pulse_kind)
          2'd1: begin
            for (int i = 0; i < NA; i++) mem[i] <= 8'hFF;
            erase_cnt <= erase_cnt + 1;
          end
          2'd2: begin mem[ta] <= mem[ta] & td; prog_cnt <= prog_cnt + 1; end
          2'd3: begin rd <= mem[ta]; fld <= 5; read_cnt <= read_cnt + 1; end
          default: ;
        endcase
      end
      if (pulse && pulse_kind == 2'd1) erase_len <= erase_len + 1;
      if (pulse && pulse_kind == 2'd2) prog_len <= prog_len + 1;
    end
  end

  // Stage log and stage durations
  logic [2:0] slog [8];
  int slog_n, enter_cnt, exit_cnt;
  logic [2:0] prev_stage;

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      slog_n <= 0; enter_cnt <= 0; exit_cnt <= 0; prev_stage <= 3'd0;
      for (int i = 0; i < 8; i++) slog[i] <= 3'd0;
    end else begin
      prev_stage <= stage;
      if (stage != prev_stage && stage != 3'd0 && slog_n < 8) begin
        slog[slog_n] <= stage;
        slog_n <= slog_n + 1;
      end
      if (stage == 3'd1) enter_cnt <= enter_cnt + 1;
      if (stage == 3'd6) exit_cnt <= exit_cnt + 1;
    end
  end

  // Pattern source with programmable stall
  int pv_cnt, hs_cnt, exp_a, acc_err;
  assign pat_data = pat[pat_addr];

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      pat_valid <= 1'b0; pv_cnt <= 0; hs_cnt <= 0; exp_a <= 0; acc_err <= 0;
    end else if (pat_valid && pat_ready) begin
      pat_valid <= 1'b0;
      pv_cnt <= 0;
      hs_cnt <= hs_cnt + 1;
      if (int'(pat_addr) != exp_a) acc_err <= acc_err + 1;
      exp_a <= (exp_a == NA - 1) ? 0 : exp_a + 1;
    end else if (pat_ready && !pat_valid) begin
      if (pv_cnt >= stall_n) pat_valid <= 1'b1;
      else pv_cnt <= pv_cnt + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(logic vo);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; verify_only = vo; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk({req, " completion"}, int'(done), 1);
  endtask

  task automatic chk_log(string req, int n, int s0, int s1, int s2, int s3, int s4, int s5);
    int exp[6];
    exp = '{s0, s1, s2, s3, s4, s5};
    chk({req, " stage count"}, slog_n, n);
    for (int i = 0; i < n; i++) chk({req, " stage order"}, int'(slog[i]), exp[i]);
  endtask

  task automatic t_reset;
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(done), 0);
    chk("R12 stage", int'(stage), 0);
    chk("R12 tck_en", int'(tck_en), 0);
    chk("R12 pulse", int'(pulse), 0);
    chk("R12 pat_ready", int'(pat_ready), 0);
    chk("R12 flags", int'(id_fail) + int'(vfy_fail), 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < NA; i++) pat[i] = DW'(i * 37 + 5);
    stall_n = 0;
    kick(1'b0);
    chk("R11 busy after start", int'(busy), 1);
    wait_done("R1");
    chk_log("R1", 6, 1, 2, 3, 4, 5, 6);
    chk("R3 enter length", enter_cnt, MODE_CYC);
    chk("R3 exit length", exit_cnt, MODE_CYC);
    chk("R4 erase pulses", erase_cnt, 1);
    chk("R4 erase length", erase_len, ERASE_CYC);
    chk("R5 program pulses", prog_cnt, NA);
    chk("R5 program length", prog_len, NA * PCYC);
    for (int i = 0; i < NA; i++) chk("R5 memory word", int'(mem[i]), int'(pat[i]));
    chk("R6 read pulses", read_cnt, NA);
    chk("R6 verify pass", int'(vfy_fail), 0);
    chk("R9 opcode decode", bad_op, 0);
    chk("R10 handshakes", hs_cnt, 2 * NA);
    chk("R10 address order", acc_err, 0);
    chk("R7 id ok", int'(id_fail), 0);
    chk("R11 not busy at done", int'(busy), 0);
  endtask

  task automatic t_verify_ok;
    stall_n = 3;
    kick(1'b1);
    wait_done("R2");
    chk_log("R2", 4, 1, 2, 5, 6, 0, 0);
    chk("R2 no erase", erase_cnt, 0);
    chk("R2 no program", prog_cnt, 0);
    chk("R6 verify pass stalled", int'(vfy_fail), 0);
    chk("R10 stalled handshakes", hs_cnt, NA);
    chk("R10 stalled order", acc_err, 0);
  endtask

  task automatic t_verify_bad;
    pat[2] = pat[2] ^ 8'h01;
    pat[5] = pat[5] ^ 8'h80;
    stall_n = 1;
    kick(1'b1);
    wait_done("R8");
    chk("R8 vfy_fail", int'(vfy_fail), 1);
    chk("R8 first fail addr", int'(fail_addr), 2);
    chk("R8 all addresses read", read_cnt, NA);
    chk("R8 all words fetched", hs_cnt, NA);
    repeat (5) @(negedge clk);
    chk("R11 done held", int'(done), 1);
    chk("R8 flag sticky", int'(vfy_fail), 1);
  endtask

  task automatic t_restart;
    for (int i = 0; i < NA; i++) pat[i] = DW'(i * 91 + 17);
    stall_n = 0;
    kick(1'b0);
    chk("R11 done cleared", int'(done), 0);
    chk("R11 vfy_fail cleared", int'(vfy_fail), 0);
    chk("R11 fail_addr cleared", int'(fail_addr), 0);
    repeat (5) @(negedge clk);
    verify_only = 1; start = 1;
    @(negedge clk); start = 0;
    wait_done("R11");
    chk_log("R11 start ignored", 6, 1, 2, 3, 4, 5, 6);
    chk("R11 erase kept", erase_cnt, 1);
    chk("R11 verify pass", int'(vfy_fail), 0);
  endtask

  task automatic t_idfail;
    tgt_id = 8'h3C;
    kick(1'b0);
    wait_done("R7");
    chk("R7 id_fail", int'(id_fail), 1);
    chk_log("R7", 3, 1, 2, 6, 0, 0, 0);
    chk("R7 no erase", erase_cnt, 0);
    chk("R7 no program", prog_cnt, 0);
    chk("R7 no read", read_cnt, 0);
    chk("R3 exit length after abort", exit_cnt, MODE_CYC);
    tgt_id = IDV;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_verify_ok();
    t_verify_bad();
    t_restart();
    t_idfail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule